// File: doc/BRIEF.md
# SPI Command-Queue Sequencer

This block is a single-lane SPI master that runs on its own from a queue of 32-bit command entries. Software, or another engine, pushes entries into a small internal queue. The sequencer pops them one at a time and carries each one out on the SPI pins. An entry does one of three things:

- It holds the chip select at a chosen level for a number of idle SCLK periods.
- It shifts out one literal command byte.
- It moves a counted run of data bytes. The count is either a literal or a power of two.

Transmit data arrives on a valid/ready byte stream. Received bytes leave as single-cycle pulses on an output byte stream. A queue-empty flag tells the producer when all pushed entries have been taken. SCLK is derived from the reference clock through a 3-bit divide field, and clock polarity and phase are set by separate configuration inputs.

The sequencer has five states:

- `ST_IDLE`: waits for an entry, then pops it and moves to `ST_DECODE`.
- `ST_DECODE`: sets the chip select and the counter. From here there are four transitions:
  - to `ST_WAIT` for an idle-cycle entry;
  - to `ST_SHIFT` for a command-byte entry;
  - to `ST_FETCH` for a data entry;
  - back to `ST_IDLE` when the count is zero.
- `ST_WAIT`: counts SCLK half periods and returns to `ST_IDLE` when the count runs out.
- `ST_FETCH`: takes the next transmit byte, or 0xFF for a receive-only entry. It moves to `ST_SHIFT`, and stalls here while the transmit stream is empty.
- `ST_SHIFT`: makes 16 SCLK edges for one byte. It then goes back to `ST_FETCH` if bytes remain, or to `ST_IDLE` when the entry is done.

Top module: `spi_cmdq_seq`

## Requirements
- R1: After reset the block shows `spi_cs_n`=1, `spi_sclk`=0 (with `cfg_cpol`=0), `queue_empty`=1, `cmd_ready`=1 and `rx_valid`=0.
- R2: An entry with bit 8 (data) and bit 16 (transmit) both clear is an idle entry. For imm = bits 7:0 SCLK periods, `spi_cs_n` takes the inverse of bit 12. When the next entry is already queued, a deasserting idle entry keeps `spi_cs_n` high for exactly 2·imm·2^div + 2 reference cycles before the next entry drives it low. `spi_cs_n` does not change while a byte is being shifted.
- R3: An entry with bit 8 clear and bit 16 set shifts the immediate byte out on `spi_mosi`, MSB first, and takes nothing from the transmit stream.
- R4: An entry with bit 8 set and bit 9 (exponent) clear moves exactly imm bytes. Each transmitted byte is taken from the transmit stream in order and shifted out MSB first.
- R5: An entry with bits 8 and 9 set moves 2^imm bytes. An exponent above CNT_W-1 is clamped to CNT_W-1, so with CNT_W=9 an exponent of 40 moves 256 bytes.
- R6: When bit 17 (receive) is set and bit 16 is clear, `spi_mosi` carries 0xFF for every byte. Each byte sampled from `spi_miso` appears once on `rx_data` with an `rx_valid` pulse, and the transmit stream is not read.
- R7: With bits 16 and 17 both set, each byte is transmitted from the stream and the byte received in the same slot is delivered on `rx_data`. `rx_valid` never stays high for two consecutive cycles.
- R8: While a transmit entry waits on an empty transmit stream, `spi_sclk` holds its level and no bit moves. Transfer resumes when data arrives.
- R9: The SCLK period during a byte is 2<<`cfg_div` reference cycles.
- R10: `spi_sclk` rests at `cfg_cpol` between bytes. With `cfg_cpha`=0, data is sampled on the leading edge and changed on the trailing edge; with `cfg_cpha`=1 the two are swapped. All four modes transfer correctly.
- R11: `queue_empty` is 1 exactly when no pushed entry is waiting to be popped. `cmd_ready` drops when the queue holds FIFO_DEPTH entries and is always 1 while the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | 3 | SCLK divide field; period is 2<<cfg_div cycles |
| cfg_cpol | input | 1 | SCLK rest level |
| cfg_cpha | input | 1 | Sample on trailing edge when 1 |
| cmd_valid | input | 1 | Command entry offered |
| cmd_word | input | 32 | Command entry |
| cmd_ready | output | 1 | Queue can accept an entry |
| queue_empty | output | 1 | No entry waiting in the queue |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Transmit byte taken on this cycle if valid |
| rx_valid | output | 1 | Received byte pulse |
| rx_data | output | 8 | Received byte |
| spi_sclk | output | 1 | SPI clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
Each entry type is driven with its own pattern:

- A lone command byte of mixed bits shows whether the immediate or stream data is being sent, and in which bit order.
- Literal and power-of-two data entries with distinct byte values expose any error in count or order. An oversized exponent confirms the clamp by producing exactly 256 bytes.
- Receive-only and full-duplex entries against a slave model, run in all four clock modes, separate the sampling edge from the shifting edge.
- A deliberately starved transmit stream, a cycle-exact chip-select gap measurement and an SCLK period measurement at a non-zero divide pin down the timing.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECODE,
        ST_WAIT,
        ST_FETCH,
        ST_SHIFT
    } seq_state_e;

    // Field positions decoded from a command entry
    localparam int F_DATA = 8;
    localparam int F_EXP  = 9;
    localparam int F_CS   = 12;
    localparam int F_TX   = 16;
    localparam int F_RX   = 17;

    typedef struct packed {
        logic       rx;
        logic       tx;
        logic       cs;
        logic       expo;
        logic       data;
        logic [7:0] imm;
    } entry_t;

    function automatic entry_t decode_entry(input logic [31:0] w);
        entry_t e;
        e.rx   = w[F_RX];
        e.tx   = w[F_TX];
        e.cs   = w[F_CS];
        e.expo = w[F_EXP];
        e.data = w[F_DATA];
        e.imm  = w[7:0];
        return e;
    endfunction

endpackage

// File: rtl/spi_cmd_fifo.sv
module spi_cmd_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             full,
    output logic             empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic [CW-1:0]    count;
    logic             do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    // Half period is 2^div reference cycles
    localparam int CW = (1 << DIV_W) - 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    assign lim  = (CW'(1) << div) - CW'(1);
    assign tick = run && (cnt == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt <= '0;
        else if (!run)  cnt <= '0;
        else if (tick)  cnt <= '0;
        else            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/spi_seq_engine.sv
module spi_seq_engine
    import spi_seq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fifo_empty,
    input  logic [31:0] fifo_data,
    output logic        fifo_pop,
    input  logic        tick,
    output logic        run,
    input  logic        cpol,
    input  logic        cpha,
    input  logic        tx_valid,
    input  logic [7:0]  tx_data,
    output logic        tx_ready,
    output logic        rx_valid,
    output logic [7:0]  rx_data,
    output logic        sclk,
    output logic        cs_n,
    output logic        mosi,
    input  logic        miso,
    output seq_state_e  state
);
    localparam logic [7:0] MAX_EXP = 8'(CNT_W - 1);

    seq_state_e       nxt;
    entry_t           ent;
    logic [CNT_W-1:0] cnt, xfer_cnt;
    logic [7:0]       exp_sel, load_byte, sreg, rsh;
    logic [3:0]       ph;
    logic             do_load, sample_edge, sclk_q, cs_q, mosi_q, rxv;
    logic [7:0]       rxd;

    assign exp_sel     = (ent.imm > MAX_EXP) ? MAX_EXP : ent.imm;
    assign xfer_cnt    = ent.expo ? (CNT_W'(1) << exp_sel) : CNT_W'(ent.imm);
    assign fifo_pop    = (state == ST_IDLE) && !fifo_empty;
    assign run         = (state == ST_WAIT) || (state == ST_SHIFT);
    assign tx_ready    = (state == ST_FETCH) && ent.tx;
    assign load_byte   = (state == ST_DECODE) ? ent.imm : (ent.tx ? tx_data : 8'hFF);
    assign do_load     = ((state == ST_DECODE) && !ent.data && ent.tx) ||
                         ((state == ST_FETCH) && (!ent.tx || tx_valid));
    // Even half-ticks are leading edges; phase picks which edge samples
    assign sample_edge = ph[0] ^ ~cpha;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (!fifo_empty) nxt = ST_DECODE;
            ST_DECODE: begin
                if (!ent.data && !ent.tx)  nxt = (ent.imm == 8'd0) ? ST_IDLE : ST_WAIT;
                else if (!ent.data)        nxt = ST_SHIFT;
                else                       nxt = (xfer_cnt == '0) ? ST_IDLE : ST_FETCH;
            end
            ST_WAIT:   if (tick && cnt == CNT_W'(1)) nxt = ST_IDLE;
            ST_FETCH:  if (!ent.tx || tx_valid) nxt = ST_SHIFT;
            ST_SHIFT:  if (tick && ph == 4'd15)
                           nxt = (cnt == CNT_W'(1)) ? ST_IDLE : ST_FETCH;
            default:   nxt = ST_IDLE;
        endcase
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent    <= '0;
            cnt    <= '0;
            ph     <= '0;
            sreg   <= '0;
            rsh    <= '0;
            sclk_q <= 1'b0;
            cs_q   <= 1'b1;
            mosi_q <= 1'b0;
            rxv    <= 1'b0;
            rxd    <= '0;
        end else begin
            rxv <= 1'b0;
            if (state != ST_SHIFT) sclk_q <= cpol;
            if (do_load) begin
                ph  <= '0;
                rsh <= '0;
                if (!cpha) begin
                    mosi_q <= load_byte[7];
                    sreg   <= {load_byte[6:0], 1'b0};
                end else begin
                    sreg   <= load_byte;
                end
            end
            unique case (state)
                ST_IDLE: if (!fifo_empty) ent <= decode_entry(fifo_data);
                ST_DECODE: begin
                    cs_q <= ~ent.cs;
                    if (!ent.data && !ent.tx) cnt <= CNT_W'({ent.imm, 1'b0});
                    else if (!ent.data)       cnt <= CNT_W'(1);
                    else                      cnt <= xfer_cnt;
                end
                ST_WAIT: if (tick) cnt <= cnt - 1'b1;
                ST_FETCH: ;
                ST_SHIFT: if (tick) begin
                    sclk_q <= ~sclk_q;
                    ph     <= ph + 1'b1;
                    if (sample_edge) begin
                        rsh <= {rsh[6:0], miso};
                    end else if (cpha || ph != 4'd15) begin
                        mosi_q <= sreg[7];
                        sreg   <= {sreg[6:0], 1'b0};
                    end
                    if (ph == 4'd15) begin
                        cnt <= cnt - 1'b1;
                        rxv <= ent.rx;
                        rxd <= cpha ? {rsh[6:0], miso} : rsh;
                    end
                end
                default: ;
            endcase
        end
    end

    assign sclk     = sclk_q;
    assign cs_n     = cs_q;
    assign mosi     = mosi_q;
    assign rx_valid = rxv;
    assign rx_data  = rxd;
endmodule

// File: rtl/spi_cmdq_seq.sv
module spi_cmdq_seq
    import spi_seq_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int CNT_W      = 16,
    parameter int DIV_W      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             cfg_cpol,
    input  logic             cfg_cpha,
    input  logic             cmd_valid,
    input  logic [31:0]      cmd_word,
    output logic             cmd_ready,
    output logic             queue_empty,
    input  logic             tx_valid,
    input  logic [7:0]       tx_data,
    output logic             tx_ready,
    output logic             rx_valid,
    output logic [7:0]       rx_data,
    output logic             spi_sclk,
    output logic             spi_cs_n,
    output logic             spi_mosi,
    input  logic             spi_miso
);
    logic        q_full, q_empty, q_pop, tick, run;
    logic [31:0] q_data;
    seq_state_e  eng_state;

    assign cmd_ready   = !q_full;
    assign queue_empty = q_empty;

    spi_cmd_fifo #(.WIDTH(32), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(cmd_valid), .din(cmd_word),
        .pop(q_pop), .dout(q_data),
        .full(q_full), .empty(q_empty)
    );

    spi_half_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(run), .div(cfg_div), .tick(tick)
    );

    spi_seq_engine #(.CNT_W(CNT_W)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .fifo_empty(q_empty), .fifo_data(q_data), .fifo_pop(q_pop),
        .tick(tick), .run(run),
        .cpol(cfg_cpol), .cpha(cfg_cpha),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data),
        .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi), .miso(spi_miso),
        .state(eng_state)
    );
endmodule

// File: rtl/spi_cmdq_chk.sv
module spi_cmdq_chk
    import spi_seq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_cpol,
    input logic       cmd_ready,
    input logic       queue_empty,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic       rx_valid,
    input logic       spi_sclk,
    input logic       spi_cs_n,
    input seq_state_e state
);
    p_room_when_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        queue_empty |-> cmd_ready);

    p_cs_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && $past(state) == ST_SHIFT) |-> $stable(spi_cs_n));

    p_rx_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    p_sclk_rest_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && $stable(cfg_cpol)) |-> (spi_sclk == cfg_cpol));

    p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && !tx_valid) |=> $stable(spi_sclk));
endmodule

bind spi_cmdq_seq spi_cmdq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol),
    .cmd_ready(cmd_ready), .queue_empty(queue_empty),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_valid(rx_valid),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .state(eng_state)
);

// File: tb/spi_cmdq_seq_test.sv
module spi_cmdq_seq_test;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n;
    logic [2:0]  cfg_div;
    logic        cfg_cpol, cfg_cpha;
    logic        cmd_valid;
    logic [31:0] cmd_word;
    logic        cmd_ready, queue_empty;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready, rx_valid;
    logic [7:0]  rx_data;
    logic        spi_sclk, spi_cs_n, spi_mosi, spi_miso;

    int checks = 0;
    int errors = 0;

    spi_cmdq_seq #(.FIFO_DEPTH(4), .CNT_W(9), .DIV_W(3)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_cpol(cfg_cpol),
        .cfg_cpha(cfg_cpha), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .cmd_ready(cmd_ready), .queue_empty(queue_empty),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .spi_sclk(spi_sclk),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // Transmit source
    logic [7:0] txq [0:1023];
    int tx_head = 0;
    int tx_tail = 0;
    assign tx_valid = (tx_head < tx_tail);
    assign tx_data  = txq[tx_head];
    always @(posedge clk) if (tx_valid && tx_ready) tx_head <= tx_head + 1;

    // Receive sink
    logic [7:0] rxcap [0:1023];
    int rx_n = 0;
    always @(posedge clk) if (rx_valid) begin
        rxcap[rx_n] <= rx_data;
        rx_n <= rx_n + 1;
    end

    // Slave model
    logic [7:0] sl_out [0:1023];
    logic [7:0] slin [0:1023];
    logic [7:0] sl_acc = 8'h00;
    int sl_bits = 0;
    int slin_n = 0;
    int oidx = 0;
    int sl_optr = 0;
    logic miso_r = 1'b0;
    assign spi_miso = cfg_cpha ? miso_r : sl_out[sl_optr][3'(7 - oidx)];

    always @(spi_sclk) begin
        if (rst_n === 1'b1 && spi_cs_n === 1'b0) begin
            if ((spi_sclk != cfg_cpol) ^ cfg_cpha) begin
                sl_acc = {sl_acc[6:0], spi_mosi};
                sl_bits++;
                if (sl_bits == 8) begin
                    slin[slin_n] = sl_acc;
                    slin_n++;
                    sl_bits = 0;
                end
            end else begin
                if (cfg_cpha) miso_r = sl_out[sl_optr][3'(7 - oidx)];
                oidx++;
                if (oidx == 8) begin
                    oidx = 0;
                    sl_optr++;
                end
            end
        end
    end

    // Pin monitors sampled at the falling clock edge
    int run_hi = 0, last_gap = 0, cyc = 0, last_rise = 0, last_per = 0, toggles = 0;
    logic prev_sclk = 1'b0;
    always @(negedge clk) begin
        cyc++;
        if (spi_cs_n) run_hi++;
        else begin
            if (run_hi > 0) last_gap = run_hi;
            run_hi = 0;
        end
        if (spi_sclk !== prev_sclk) toggles++;
        if (spi_sclk && !prev_sclk) begin
            last_per  = cyc - last_rise;
            last_rise = cyc;
        end
        prev_sclk = spi_sclk;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit cs, input bit data, input bit expo,
                                       input bit tx, input bit rx, input logic [7:0] imm);
        return {14'd0, rx, tx, 1'b0, 1'b1, 1'b0, cs, 2'b01, expo, data, imm};
    endfunction

    task automatic push(input logic [31:0] w);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_word  = w;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done();
        while (!queue_empty) @(negedge clk);
        repeat (200) @(negedge clk);
    endtask

    task automatic set_cfg(input logic [2:0] d, input bit pol, input bit pha);
        @(negedge clk);
        cfg_div = d; cfg_cpol = pol; cfg_cpha = pha;
        repeat (3) @(negedge clk);
    endtask

    task automatic add_tx(input logic [7:0] b);
        txq[tx_tail] = b;
        tx_tail++;
    endtask

    task automatic t_reset();
        chk("R1 cs_n", int'(spi_cs_n), 1);
        chk("R1 sclk", int'(spi_sclk), 0);
        chk("R1 queue_empty", int'(queue_empty), 1);
        chk("R1 cmd_ready", int'(cmd_ready), 1);
        chk("R1 rx_valid", int'(rx_valid), 0);
    endtask

    task automatic t_cmd_byte();
        int s0 = slin_n, h0 = tx_head;
        set_cfg(3'd0, 1'b0, 1'b0);
        push(mk(1, 0, 0, 0, 0, 8'd5));
        push(mk(1, 0, 0, 1, 0, 8'h9F));
        push(mk(0, 0, 0, 0, 0, 8'd5));
        wait_done();
        chk("R3 byte count", slin_n - s0, 1);
        chk("R3 msb-first byte", int'(slin[s0]), 'h9F);
        chk("R3 tx stream untouched", tx_head - h0, 0);
        chk("R2 cs released", int'(spi_cs_n), 1);
    endtask

    task automatic t_cs_gap();
        set_cfg(3'd1, 1'b0, 1'b0);
        push(mk(1, 0, 0, 0, 0, 8'd5));
        push(mk(0, 0, 0, 0, 0, 8'd7));
        push(mk(1, 0, 0, 0, 0, 8'd5));
        push(mk(0, 0, 0, 0, 0, 8'd5));
        wait_done();
        chk("R2 deassert gap cycles", last_gap, 2 * 7 * 2 + 2);
    endtask

    task automatic t_data_literal();
        int s0 = slin_n, h0 = tx_head;
        set_cfg(3'd0, 1'b0, 1'b0);
        add_tx(8'hA5); add_tx(8'h3C); add_tx(8'h81);
        push(mk(1, 0, 0, 0, 0, 8'd5));
        push(mk(1, 1, 0, 1, 0, 8'd3));
        push(mk(0, 0, 0, 0, 0, 8'd5));
        wait_done();
        chk("R4 byte count", slin_n - s0, 3);
        chk("R4 byte0", int'(slin[s0]), 'hA5);
        chk("R4 byte1", int'(slin[s0 + 1]), 'h3C);
        chk("R4 byte2", int'(slin[s0 + 2]), 'h81);
        chk("R4 stream pops", tx_head - h0, 3);
    endtask

    task automatic t_data_exp();
        int s0 = slin_n, bad = 0;
        set_cfg(3'd0, 1'b1, 1'b1);
        for (int i = 0; i < 8; i++) add_tx(8'(i * 17 + 3));
        push(mk(1, 0, 0, 0, 0, 8'd5));
        push(mk(1, 1, 1, 1, 0, 8'd3));
        push(mk(0, 0, 0, 0, 0, 8'd5));
        wait_done();
        chk("R5 exponent 3 count", slin_n - s0, 8);
        for (int i = 0; i < 8; i++) if (slin[s0 + i] !== 8'(i * 17 + 3)) bad++;
        chk("R10 mode 3 bytes intact (R5)", bad, 0);
        chk("R10 sclk rests at cpol=1", int'(spi_sclk), 1);
    endtask

    task automatic t_exp_clamp();
        int s0 = slin_n, bad = 0;
        set_cfg(3'd0, 1'b0, 1'b0);
        for (int i = 0; i < 256; i++) add_tx(8'(i));
        push(mk(1, 0, 0, 0, 0, 8'd5));
        push(mk(1, 1, 1, 1, 0, 8'd40));
        push(mk(0, 0, 0, 0, 0, 8'd5));
        wait_done();
        chk("R5 clamped count", slin_n - s0, 256);
        for (int i = 0; i < 256; i++) if (slin[s0 + i] !== 8'(i)) bad++;
        chk("R5 clamped data", bad, 0);
    endtask

    task automatic t_rx_only();
        int s0 = slin_n, r0 = rx_n, h0 = tx_head, bad = 0;
        logic [7:0] pat [4];
        pat[0] = 8'hC3; pat[1] = 8'h5A; pat[2] = 8'h0F; pat[3] = 8'h96;
        set_cfg(3'd0, 1'b0, 1'b1);
        for (int i = 0; i < 4; i++) sl_out[sl_optr + i] = pat[i];
        push(mk(1, 0, 0, 0, 0, 8'd5));
        push(mk(1, 1, 0, 0, 1, 8'd4));
        push(mk(0, 0, 0, 0, 0, 8'd5));
        wait_done();
        chk("R6 rx count", rx_n - r0, 4);
        for (int i = 0; i < 4; i++) chk("R6 rx byte (R10 mode 1)", int'(rxcap[r0 + i]), int'(pat[i]));
        for (int i = 0; i < 4; i++) if (slin[s0 + i] !== 8'hFF) bad++;
        chk("R6 mosi all ones", bad, 0);
        chk("R6 tx stream untouched", tx_head - h0, 0);
    endtask

    task automatic t_duplex();
        int s0 = slin_n, r0 = rx_n;
        set_cfg(3'd0, 1'b1, 1'b0);
        sl_out[sl_optr] = 8'h6E; sl_out[sl_optr + 1] = 8'hB1;
        add_tx(8'h12); add_tx(8'hED);
        push(mk(1, 0, 0, 0, 0, 8'd5));
        push(mk(1, 1, 0, 1, 1, 8'd2));
        push(mk(0, 0, 0, 0, 0, 8'd5));
        wait_done();
        chk("R7 tx byte0 (R10 mode 2)", int'(slin[s0]), 'h12);
        chk("R7 tx byte1", int'(slin[s0 + 1]), 'hED);
        chk("R7 rx byte0", int'(rxcap[r0]), 'h6E);
        chk("R7 rx byte1", int'(rxcap[r0 + 1]), 'hB1);
    endtask

    task automatic t_stall();
        int s0 = slin_n, t0;
        set_cfg(3'd0, 1'b0, 1'b0);
        push(mk(1, 0, 0, 0, 0, 8'd5));
        push(mk(1, 1, 0, 1, 0, 8'd2));
        repeat (60) @(negedge clk);
        t0 = toggles;
        repeat (100) @(negedge clk);
        chk("R8 sclk frozen while starved", toggles - t0, 0);
        chk("R8 no byte while starved", slin_n - s0, 0);
        add_tx(8'h4B); add_tx(8'hD2);
        push(mk(0, 0, 0, 0, 0, 8'd5));
        wait_done();
        chk("R8 resumed byte0", int'(slin[s0]), 'h4B);
        chk("R8 resumed byte1", int'(slin[s0 + 1]), 'hD2);
    endtask

    task automatic t_period();
        set_cfg(3'd2, 1'b0, 1'b0);
        add_tx(8'h77);
        push(mk(1, 0, 0, 0, 0, 8'd1));
        push(mk(1, 1, 0, 1, 0, 8'd1));
        push(mk(0, 0, 0, 0, 0, 8'd1));
        wait_done();
        chk("R9 sclk period div=2", last_per, 8);
    endtask

    task automatic t_queue();
        set_cfg(3'd0, 1'b0, 1'b0);
        for (int i = 0; i < 5; i++) push(mk(0, 0, 0, 0, 0, 8'd20));
        chk("R11 ready low when full", int'(cmd_ready), 0);
        chk("R11 not empty while queued", int'(queue_empty), 0);
        wait_done();
        chk("R11 empty after drain", int'(queue_empty), 1);
        chk("R11 ready after drain", int'(cmd_ready), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung run, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) sl_out[i] = 8'h00;
        rst_n = 1'b0; cfg_div = 3'd0; cfg_cpol = 1'b0; cfg_cpha = 1'b0;
        cmd_valid = 1'b0; cmd_word = '0;
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_cmd_byte();
        t_cs_gap();
        t_data_literal();
        t_data_exp();
        t_exp_clamp();
        t_rx_only();
        t_duplex();
        t_stall();
        t_period();
        t_queue();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule